// File: doc/BRIEF.md
# Tandem-Plane Output Column Arbiter

This block holds the per-input crosspoint buffers that feed one output port of an N-input switch built from K logical crossbar planes. Each crosspoint keeps at most one cell and records which plane the cell is on. Every clock cycle is one cell slot. In each slot, every plane runs its own rotating arbiter over the crosspoints whose cell sits on that plane. A cell that wins goes to the output in that slot. A cell that loses steps to the next plane, and after the last plane it returns to the first.

Because every plane grants independently, the output can receive up to K cells in one slot, one from each plane. The input side reads the per-crosspoint busy flag and holds back a new cell while the flag is set. Each crosspoint therefore never holds more than one cell, and cells from one input leave in the order they entered.

Top module: `tdx_out_column`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, all crosspoints are emptied and every plane's pointer returns to input 0. After that edge, `busy` and `out_valid` are all zero.
- R2: A `load_valid[i]` sampled at an edge while `busy[i]` is 0 stores the cell in crosspoint i on plane 0 (the first plane). From the next cycle, `busy[i]` is 1 and the cell requests plane 0.
- R3: A `load_valid[i]` while `busy[i]` is 1 has no effect. The stored cell and its data stay unchanged.
- R4: In each slot, each plane grants at most one requester. The winner is the first requesting input found by searching upward from the plane's pointer and wrapping from N-1 to 0. After a grant, the pointer moves to one past the granted input. Without a grant, it stays where it is.
- R5: A cell on plane p that is not granted sits on plane p+1 in the next slot. From plane K-1 it moves back to plane 0.
- R6: A granted cell leaves its crosspoint at the end of the slot. `busy[i]` stays 1 during the grant slot and is 0 in the next slot, when a new cell can be loaded.
- R7: Several planes can grant in the same slot. With enough traffic, all K bits of `out_valid` are 1 together, and each comes from a different input.
- R8: Lane p of the output (bits `p*DATA_W +: DATA_W` of `out_data`, bits `p*IDX_W +: IDX_W` of `out_src`) carries the data and the input index of plane p's granted cell. Both lanes are zero when `out_valid[p]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one cycle per cell slot |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | N_IN | Offer of a new cell per input |
| load_data | input | N_IN*DATA_W | Cell data per input, input i in bits i*DATA_W +: DATA_W |
| busy | output | N_IN | Crosspoint i holds a cell |
| out_valid | output | K | Plane p delivers a cell this slot |
| out_data | output | K*DATA_W | Delivered cell data, one lane per plane |
| out_src | output | K*IDX_W | Source input index, one lane per plane |

## Verification
`busy`, `out_valid`, `out_data` and `out_src` are driven only by crosspoint and pointer registers. A cell loaded at one edge therefore shows up on plane 0 in the cycle right after that edge. Its grant or its step to the next plane takes effect at the following edge. The bench samples every output on the falling edge, compares it against a reference model that has been advanced once per rising edge, and only then drives the next inputs and advances the model. Directed sequences check exact slot numbers: the rotation to plane 1, the wrap back to plane 0 in the fourth slot, a reload refused while busy, and a slot where all three planes deliver.

// File: rtl/tdx_pkg.sv
// Package: shared helpers for the tandem-plane output column.
// Assumes: callers pass counts of at least 1.
package tdx_pkg;
    // Width of an index able to address n items (minimum 1 bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tdx_rr_arbiter.sv
// Module: rotating-pointer arbiter for one plane.
// Grants the first requester at or above the pointer, wrapping around.
// The pointer moves to one past the winner, and only when a grant is made.
// Assumes: synchronous active-low reset, one grant per cycle.
module tdx_rr_arbiter #(
    parameter int N_REQ = 8,
    localparam int IDX_W = tdx_pkg::idx_width(N_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] ptr_q;

    // Search upward from the pointer for the first requester.
    always_comb begin
        int c;
        gnt     = '0;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = 0; off < N_REQ; off++) begin
            c = int'(ptr_q) + off;
            if (c >= N_REQ) c = c - N_REQ;
            if (!gnt_vld && req[c]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(c);
            end
        end
        if (gnt_vld) gnt[gnt_idx] = 1'b1;
    end

    // Move the pointer to one past the winner after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gnt_vld) begin
            ptr_q <= (int'(gnt_idx) == N_REQ - 1) ? '0 : gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/tdx_crosspoint.sv
// Module: one-cell crosspoint buffer that tracks the plane of its cell.
// Loads only when empty, and a loaded cell starts on plane 0. A granted
// cell leaves at the edge. A denied cell steps to the next plane, wrapping
// from the last plane back to plane 0.
// Assumes: grant is asserted only while the buffer is full.
module tdx_crosspoint #(
    parameter int N_PLANES = 3,
    parameter int DATA_W   = 32,
    localparam int PL_W    = tdx_pkg::idx_width(N_PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    input  logic              grant,
    output logic              full,
    output logic [PL_W-1:0]   plane,
    output logic [DATA_W-1:0] data
);
    // Hold, load, release or rotate the stored cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            plane <= '0;
            data  <= '0;
        end else if (full) begin
            if (grant) begin
                full <= 1'b0;
            end else begin
                plane <= (int'(plane) == N_PLANES - 1) ? '0 : plane + 1'b1;
            end
        end else if (load_valid) begin
            full  <= 1'b1;
            plane <= '0;
            data  <= load_data;
        end
    end
endmodule

// File: rtl/tdx_out_column.sv
// Module: all crosspoints that feed one output port across K tandem planes.
// One arbiter per plane picks among the crosspoints whose cell sits on
// that plane. Each plane's winner is driven onto that plane's output lane.
// Assumes: one clock cycle per cell slot, and the input side honours busy.
module tdx_out_column #(
    parameter int N_IN     = 8,
    parameter int N_PLANES = 3,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = tdx_pkg::idx_width(N_IN),
    localparam int PL_W    = tdx_pkg::idx_width(N_PLANES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          load_valid,
    input  logic [N_IN*DATA_W-1:0]   load_data,
    output logic [N_IN-1:0]          busy,
    output logic [N_PLANES-1:0]      out_valid,
    output logic [N_PLANES*DATA_W-1:0] out_data,
    output logic [N_PLANES*IDX_W-1:0]  out_src
);
    logic [N_IN-1:0]   xp_full;
    logic [PL_W-1:0]   xp_plane [N_IN];
    logic [DATA_W-1:0] xp_data  [N_IN];
    logic [N_IN-1:0]   xp_grant;
    logic [N_IN-1:0]   pl_req [N_PLANES];
    logic [N_IN-1:0]   pl_gnt [N_PLANES];
    logic              pl_vld [N_PLANES];
    logic [IDX_W-1:0]  pl_idx [N_PLANES];

    genvar gi, gp;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_xp
            tdx_crosspoint #(.N_PLANES(N_PLANES), .DATA_W(DATA_W)) xp_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_valid (load_valid[gi]),
                .load_data  (load_data[gi*DATA_W +: DATA_W]),
                .grant      (xp_grant[gi]),
                .full       (xp_full[gi]),
                .plane      (xp_plane[gi]),
                .data       (xp_data[gi])
            );
            // Combine this input's grants from all planes.
            always_comb begin
                xp_grant[gi] = 1'b0;
                for (int p = 0; p < N_PLANES; p++) begin
                    xp_grant[gi] = xp_grant[gi] | pl_gnt[p][gi];
                end
            end
        end

        for (gp = 0; gp < N_PLANES; gp++) begin : g_plane
            // Collect the crosspoints whose cell sits on this plane.
            always_comb begin
                for (int i = 0; i < N_IN; i++) begin
                    pl_req[gp][i] = xp_full[i] && (xp_plane[i] == PL_W'(gp));
                end
            end

            tdx_rr_arbiter #(.N_REQ(N_IN)) arb_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (pl_req[gp]),
                .gnt     (pl_gnt[gp]),
                .gnt_vld (pl_vld[gp]),
                .gnt_idx (pl_idx[gp])
            );

            // Drive this plane's output lane, zeroed when there is no winner.
            always_comb begin
                out_valid[gp] = pl_vld[gp];
                out_data[gp*DATA_W +: DATA_W] = pl_vld[gp] ? xp_data[pl_idx[gp]] : '0;
                out_src[gp*IDX_W +: IDX_W]    = pl_vld[gp] ? pl_idx[gp] : '0;
            end
        end
    endgenerate

    assign busy = xp_full;
endmodule

// File: rtl/tdx_out_column_chk.sv
// Module: assertion checker for tdx_out_column, attached by bind.
// Watches only the top-level ports and relates them across slots.
module tdx_out_column_chk #(
    parameter int N_IN     = 8,
    parameter int N_PLANES = 3,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = tdx_pkg::idx_width(N_IN)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_IN-1:0]            load_valid,
    input logic [N_IN*DATA_W-1:0]     load_data,
    input logic [N_IN-1:0]            busy,
    input logic [N_PLANES-1:0]        out_valid,
    input logic [N_PLANES*DATA_W-1:0] out_data,
    input logic [N_PLANES*IDX_W-1:0]  out_src
);
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (busy == '0 && out_valid == '0)); // R1

    AST_LOAD_ENTERS_PLANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (|(load_valid & ~busy)) |=> out_valid[0]); // R2

    AST_CELL_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(busy) == $past($countones(busy)) - $past($countones(out_valid))
                  + $past($countones(load_valid & ~busy)))); // R6

    AST_VALID_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> ($countones(out_valid) <= $countones(busy))); // R4

    genvar gi, gp, gq;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_in
            AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                (load_valid[gi] && !busy[gi]) |=> busy[gi]); // R2
        end
        for (gp = 0; gp < N_PLANES; gp++) begin : g_pl
            AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[gp] |-> (int'(out_src[gp*IDX_W +: IDX_W]) < N_IN)); // R8
            AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !out_valid[gp] |-> (out_data[gp*DATA_W +: DATA_W] == '0)); // R8
            for (gq = gp + 1; gq < N_PLANES; gq++) begin : g_pair
                AST_DISTINCT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid[gp] && out_valid[gq]) |->
                    (out_src[gp*IDX_W +: IDX_W] != out_src[gq*IDX_W +: IDX_W])); // R7
            end
        end
    endgenerate
endmodule

bind tdx_out_column tdx_out_column_chk #(
    .N_IN(N_IN), .N_PLANES(N_PLANES), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_src(out_src)
);

// File: tb/tdx_out_column_tb_top.sv
// Bench: reference model of the crosspoint column, directed corner cases,
// then seeded random traffic. Outputs are compared on the falling edge.
module tdx_out_column_tb_top;
    localparam int N  = 5;
    localparam int K  = 3;
    localparam int W  = 32;
    localparam int IW = tdx_pkg::idx_width(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     load_valid = '0;
    logic [N*W-1:0]   load_data = '0;
    logic [N-1:0]     busy;
    logic [K-1:0]     out_valid;
    logic [K*W-1:0]   out_data;
    logic [K*IW-1:0]  out_src;

    int n_chk = 0;
    int n_bad = 0;
    int max_lanes = 0;

    // Reference model state.
    bit       m_full [N];
    int       m_pl   [N];
    bit [W-1:0] m_dat [N];
    int       m_ptr  [K];

    tdx_out_column #(.N_IN(N), .N_PLANES(K), .DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
        .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_src(out_src)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Index granted on plane p by the model, or -1.
    function automatic int m_grant(input int p);
        for (int off = 0; off < N; off++) begin
            int c = (m_ptr[p] + off) % N;
            if (m_full[c] && m_pl[c] == p) return c;
        end
        return -1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin m_full[i] = 0; m_pl[i] = 0; m_dat[i] = '0; end
        for (int p = 0; p < K; p++) m_ptr[p] = 0;
    endtask

    // Compare every output against the model for the current slot.
    task automatic compare();
        int lanes = 0;
        for (int i = 0; i < N; i++) check("R2 R3 R6 busy", 64'(busy[i]), 64'(m_full[i]));
        for (int p = 0; p < K; p++) begin
            int g = m_grant(p);
            check("R4 R5 valid", 64'(out_valid[p]), 64'(g >= 0));
            check("R4 R8 src", 64'(out_src[p*IW +: IW]), (g >= 0) ? 64'(g) : 64'd0);
            check("R8 data", 64'(out_data[p*W +: W]), (g >= 0) ? 64'(m_dat[g]) : 64'd0);
            if (out_valid[p]) lanes++;
        end
        if (lanes > max_lanes) max_lanes = lanes;
    endtask

    // Advance the model across one rising edge with the given inputs.
    task automatic m_step(input logic [N-1:0] lv, input logic [N*W-1:0] ld);
        int g [K];
        bit won [N];
        for (int i = 0; i < N; i++) won[i] = 0;
        for (int p = 0; p < K; p++) begin
            g[p] = m_grant(p);
            if (g[p] >= 0) begin won[g[p]] = 1; m_ptr[p] = (g[p] + 1) % N; end
        end
        for (int i = 0; i < N; i++) begin
            if (m_full[i]) begin
                if (won[i]) m_full[i] = 0;
                else m_pl[i] = (m_pl[i] + 1) % K;
            end else if (lv[i]) begin
                m_full[i] = 1; m_pl[i] = 0; m_dat[i] = ld[i*W +: W];
            end
        end
    endtask

    // One slot: check outputs, apply the next inputs, advance the model.
    task automatic slot(input logic [N-1:0] lv, input logic [N*W-1:0] ld);
        @(negedge clk);
        compare();
        load_valid = lv;
        load_data  = ld;
        m_step(lv, ld);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; load_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 valid after reset", 64'(out_valid), 64'd0);
    endtask

    function automatic logic [N*W-1:0] pattern(input int base);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(32'hA000_0000 + base * 16 + i);
        return v;
    endfunction

    initial begin
        logic [N*W-1:0] ld;
        void'($urandom(32'd20240611));
        do_reset();

        // R1, R5: four cells at once; pointer starts at input 0, wrap in slot 4.
        slot(5'b01111, pattern(1));
        @(negedge clk); check("R1 first grant src", 64'(out_src[0 +: IW]), 64'd0);
        compare(); m_step('0, '0); load_valid = '0;
        @(negedge clk); check("R5 step to plane1", 64'(out_valid), 64'b010);
        compare(); m_step('0, '0);
        @(negedge clk); check("R5 step to plane2", 64'(out_valid), 64'b100);
        compare(); m_step('0, '0);
        @(negedge clk); check("R5 wrap to plane0", 64'(out_valid), 64'b001);
        check("R5 wrap src", 64'(out_src[0 +: IW]), 64'd3);
        compare(); m_step('0, '0);

        // R3, R6: reload refused while busy, freed one slot after grant.
        do_reset();
        ld = pattern(2);
        slot(5'b00100, ld);
        @(negedge clk);
        check("R8 lone cell data", 64'(out_data[0 +: W]), 64'(ld[2*W +: W]));
        check("R6 busy in grant slot", 64'(busy[2]), 64'd1);
        compare();
        load_valid = 5'b00100; load_data = pattern(3); m_step(5'b00100, pattern(3));
        @(negedge clk);
        check("R3 busy reload ignored", 64'(busy[2]), 64'd0);
        check("R3 no output from ignored load", 64'(out_valid), 64'd0);
        compare(); load_valid = '0; m_step('0, '0);

        // R7: saturate every input; all planes must deliver together.
        do_reset();
        max_lanes = 0;
        for (int s = 0; s < 16; s++) slot('1, pattern(10 + s));
        slot('0, '0);
        check("R7 all planes in one slot", 64'(max_lanes), 64'(K));

        // Random traffic checked against the model.
        do_reset();
        for (int s = 0; s < 3000; s++) begin
            logic [N-1:0] lv;
            for (int i = 0; i < N; i++) begin
                lv[i] = ($urandom % 100) < ((s / 500) * 15 + 10);
                ld[i*W +: W] = $urandom;
            end
            slot(lv, ld);
            if (s == 1500) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1; m_reset(); load_valid = '0;
                check("R1 mid-run reset", 64'(busy), 64'd0);
            end
        end
        slot('0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule